// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

The block is a memory-mapped interval timer with several independent channels. Software reaches it over an APB-style register bus. Each channel has three parts: a control field, a reload value and a down-counter. While the channel is enabled, the counter steps down once per count tick. On the tick that finds the counter at zero, the counter reloads from the reload value and the channel's status flag is set.

Each channel picks its own count tick in its control field. The tick is either every bus clock cycle or a shared external tick input, which is assumed to be already synchronised. The per-channel bits in the enable, interrupt-enable and status words sit four bits apart. The status flags clear when a 1 is written to them. A single interrupt line is raised while any channel has both its status bit and its interrupt-enable bit set.

A typical use is a free-running channel with a reload of all ones, read back as a time base. Alongside it, another channel is reprogrammed for each event: disable it, write a new reload, then re-enable it to start a fresh countdown.

Top module: `apb_pit`

## Requirements
- R1: After reset, every control, reload, counter, enable, interrupt-enable and status bit is 0 and `irq` is low.
- R2: A read of offset 0x00 returns the parameter `ID_VAL`, which defaults to 0x5449_0001. A read of offset 0x10 returns the channel count, which is 4. Reads of any unmapped offset, such as 0x04, 0x0C or 0x60, return 0.
- R3: A channel whose control bit 3 is 1 decrements its counter by one on every clock while it is enabled. The counter, at offset 0x28 + 0x10·n, reads back the live count.
- R4: A channel whose control bit 3 is 0 decrements only on clocks where `ext_tick` is high. On other clocks its count holds.
- R5: On a tick with the counter at 0, the counter reloads from the reload register (offset 0x24 + 0x10·n). The same tick sets status bit 4·n at offset 0x18, whatever the interrupt-enable bit holds.
- R6: Writing 1 to status bit 4·n clears it. Writing 0 to that bit leaves it unchanged.
- R7: `irq` is high exactly while some channel n has both status bit 4·n and interrupt-enable bit 4·n (offset 0x14) set.
- R8: Writing enable bit 4·n (offset 0x1C) from 0 to 1 loads the counter from the reload register. A disabled channel's counter holds its value.
- R9: A bus write to the counter register sets the count directly. Such a write takes priority over a tick in the same cycle.
- R10: An enabled channel with reload 0 underflows on every tick. Its status bit therefore reads 1 right after a clearing write.
- R11: Only bits 4·n of the enable, interrupt-enable and status words exist, and all other bits read 0. Only control bits 3:0 are stored: bit 3 is the clock select and bits 2:0 are the mode, which is read back but always counts as 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and count clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for a write access |
| paddr | input | AW (8) | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for `paddr`, combinational |
| ext_tick | input | 1 | Synchronised external count tick |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is an underflow and a status-clearing write landing on the same edge. On that edge the set has to win. The bench reaches it with a channel on reload 0 and the bus clock as its tick, because that channel underflows on every edge. Any clearing write is therefore certain to collide with an underflow, and the status is read straight afterwards. A second timing-sensitive case is a direct counter write that lands on a counting edge. The bench reads the count in the half-cycle after the commit edge, which pins down that the written value beat the decrement.

// File: rtl/apb_pit.sv
module apb_pit #(
  parameter int          NCH    = 4,
  parameter int          CW     = 32,
  parameter int          AW     = 8,
  parameter logic [31:0] ID_VAL = 32'h5449_0001
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic          ext_tick,
  output logic          irq
);
  localparam logic [AW-1:0] A_ID  = AW'(8'h00);
  localparam logic [AW-1:0] A_CFG = AW'(8'h10);
  localparam logic [AW-1:0] A_IEN = AW'(8'h14);
  localparam logic [AW-1:0] A_STA = AW'(8'h18);
  localparam logic [AW-1:0] A_EN  = AW'(8'h1C);

  logic                    wr;
  logic [NCH-1:0]          en, ien, sta, wbit, tick, uf, en_on;
  logic [NCH-1:0][3:0]     ctl;
  logic [NCH-1:0][CW-1:0]  rld, cnt;

  assign wr  = psel && penable && pwrite;
  assign irq = |(sta & ien);

  function automatic logic [31:0] spread(input logic [NCH-1:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < NCH; i++) r[4*i] = v[i];
    return r;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(32 + 16*c);
    logic hit_ctl, hit_rld, hit_cnt;
    assign wbit[c]  = pwdata[4*c];
    assign hit_ctl  = wr && paddr == BASE;
    assign hit_rld  = wr && paddr == BASE + AW'(4);
    assign hit_cnt  = wr && paddr == BASE + AW'(8);
    assign en_on[c] = wr && paddr == A_EN && wbit[c] && !en[c];
    assign tick[c]  = en[c] && (ctl[c][3] || ext_tick);
    assign uf[c]    = tick[c] && cnt[c] == '0 && !hit_cnt;

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        ctl[c] <= '0;
        rld[c] <= '0;
        cnt[c] <= '0;
      end else begin
        if (hit_ctl) ctl[c] <= pwdata[3:0];
        if (hit_rld) rld[c] <= pwdata[CW-1:0];
        if (hit_cnt)        cnt[c] <= pwdata[CW-1:0];
        else if (en_on[c])  cnt[c] <= rld[c];
        else if (uf[c])     cnt[c] <= rld[c];
        else if (tick[c])   cnt[c] <= cnt[c] - CW'(1);
      end
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en  <= '0;
      ien <= '0;
      sta <= '0;
    end else begin
      if (wr && paddr == A_EN)  en  <= wbit;
      if (wr && paddr == A_IEN) ien <= wbit;
      sta <= (sta & ~((wr && paddr == A_STA) ? wbit : '0)) | uf;
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_ID:    prdata = ID_VAL;
      A_CFG:   prdata = 32'(NCH);
      A_IEN:   prdata = spread(ien);
      A_STA:   prdata = spread(sta);
      A_EN:    prdata = spread(en);
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (paddr == AW'(32 + 16*c))     prdata = {28'b0, ctl[c]};
          if (paddr == AW'(36 + 16*c))     prdata = 32'(rld[c]);
          if (paddr == AW'(40 + 16*c))     prdata = 32'(cnt[c]);
        end
      end
    endcase
  end
endmodule

// File: rtl/apb_pit_chk.sv
module apb_pit_chk #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input logic                   pclk,
  input logic                   presetn,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic [AW-1:0]          paddr,
  input logic [31:0]            pwdata,
  input logic                   ext_tick,
  input logic                   irq,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0]         ien,
  input logic [NCH-1:0]         sta,
  input logic [NCH-1:0][3:0]    ctl,
  input logic [NCH-1:0][CW-1:0] rld,
  input logic [NCH-1:0][CW-1:0] cnt
);
  logic bw;
  assign bw = psel && penable && pwrite;

  for (genvar c = 0; c < NCH; c++) begin : g_a
    localparam logic [AW-1:0] CA = AW'(40 + 16*c);
    localparam logic [AW-1:0] RA = AW'(36 + 16*c);
    logic no_cw, no_ew;
    assign no_cw = !(bw && paddr == CA);
    assign no_ew = !(bw && paddr == AW'(8'h1C));

    a_r3_dec: assert property (@(posedge pclk) disable iff (!presetn)
      en[c] && ctl[c][3] && cnt[c] != '0 && no_cw |=> cnt[c] == $past(cnt[c]) - CW'(1));

    a_r4_ext_hold: assert property (@(posedge pclk) disable iff (!presetn)
      en[c] && !ctl[c][3] && !ext_tick && no_cw |=> $stable(cnt[c]));

    a_r5_reload: assert property (@(posedge pclk) disable iff (!presetn)
      en[c] && ctl[c][3] && cnt[c] == '0 && no_cw && !(bw && paddr == RA)
      |=> cnt[c] == $past(rld[c]) && sta[c]);

    a_r6_w1c: assert property (@(posedge pclk) disable iff (!presetn)
      bw && paddr == AW'(8'h18) && pwdata[4*c] && !en[c] |=> !sta[c]);

    a_r7_irq: assert property (@(posedge pclk) disable iff (!presetn)
      sta[c] && ien[c] |-> irq);

    a_r8_hold: assert property (@(posedge pclk) disable iff (!presetn)
      !en[c] && no_cw && no_ew |=> $stable(cnt[c]));
  end
endmodule

bind apb_pit apb_pit_chk #(.NCH(NCH), .CW(CW), .AW(AW)) chk_i (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .ext_tick(ext_tick),
  .irq(irq), .en(en), .ien(ien), .sta(sta), .ctl(ctl), .rld(rld), .cnt(cnt)
);

// File: tb/apb_pit_tb_top.sv
module apb_pit_tb_top;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0, ext_tick = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata, rv;
  logic        irq;
  int          total = 0, bad = 0;

  always #2 pclk = ~pclk;

  apb_pit dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ext_tick(ext_tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    paddr = a; #1 d = prdata;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    // R1 / R2 reset state and fixed registers
    rd(8'h00, rv); chk("R2 id", rv, 32'h5449_0001);
    rd(8'h10, rv); chk("R2 cfg", rv, 32'd4);
    foreach (rv[i]) ;
    for (int a = 8'h14; a <= 8'h5C; a += 4) begin
      rd(8'(a), rv); chk("R1 reset reg", rv, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    rd(8'h04, rv); chk("R2 unmapped", rv, 0);
    rd(8'h0C, rv); chk("R2 unmapped", rv, 0);
    rd(8'h60, rv); chk("R2 unmapped", rv, 0);

    // R3 / R8 bus-clock sweep over every channel
    for (int c = 0; c < 4; c++) begin
      wr(8'(36 + 16*c), 32'(20 + c));
      wr(8'(32 + 16*c), 32'h9);
      wr(8'h1C, 32'(1) << (4*c));
      rd(8'(40 + 16*c), rv); chk("R8 load on enable", rv, 32'(20 + c));
      for (int k = 1; k <= 3; k++) begin
        @(negedge pclk);
        rd(8'(40 + 16*c), rv); chk("R3 decrement", rv, 32'(20 + c - k));
      end
      wr(8'h1C, 0);
    end

    // R5 / R7 / R6 underflow, interrupt and clearing on channel 0
    wr(8'h24, 2); wr(8'h1C, 1);
    rd(8'h28, rv); chk("R5 start", rv, 2);
    @(negedge pclk); rd(8'h28, rv); chk("R3 count", rv, 1);
    @(negedge pclk); rd(8'h28, rv); chk("R3 count", rv, 0);
    @(negedge pclk); rd(8'h28, rv); chk("R5 reload", rv, 2);
    rd(8'h18, rv); chk("R5 status set", rv, 32'h1);
    chk("R7 irq masked", {31'b0, irq}, 0);
    wr(8'h1C, 0);
    wr(8'h14, 1);
    chk("R7 irq on", {31'b0, irq}, 1);
    wr(8'h18, 0);
    rd(8'h18, rv); chk("R6 write zero keeps", rv & 32'h1, 32'h1);
    wr(8'h18, 1);
    rd(8'h18, rv); chk("R6 cleared", rv & 32'h1, 0);
    chk("R7 irq off", {31'b0, irq}, 0);
    wr(8'h14, 0);

    // R4 external tick on channel 1
    wr(8'h34, 5); wr(8'h30, 32'h1); wr(8'h1C, 32'h10);
    rd(8'h38, rv); chk("R4 start", rv, 5);
    repeat (3) @(negedge pclk);
    rd(8'h38, rv); chk("R4 hold without tick", rv, 5);
    ext_tick = 1; @(negedge pclk); ext_tick = 0;
    rd(8'h38, rv); chk("R4 one tick", rv, 4);
    ext_tick = 1; repeat (2) @(negedge pclk); ext_tick = 0;
    rd(8'h38, rv); chk("R4 two ticks", rv, 2);
    wr(8'h1C, 0);

    // R9 / R8 direct counter writes and restart on channel 2
    wr(8'h48, 77);
    rd(8'h48, rv); chk("R9 direct write", rv, 77);
    repeat (4) @(negedge pclk);
    rd(8'h48, rv); chk("R8 disabled hold", rv, 77);
    wr(8'h40, 32'h9); wr(8'h44, 1000); wr(8'h1C, 32'h100);
    rd(8'h48, rv); chk("R8 load", rv, 1000);
    wr(8'h48, 300);
    rd(8'h48, rv); chk("R9 write beats tick", rv, 300);
    @(negedge pclk); rd(8'h48, rv); chk("R3 after write", rv, 299);
    wr(8'h1C, 0); wr(8'h44, 50); wr(8'h1C, 32'h100);
    rd(8'h48, rv); chk("R8 fresh countdown", rv, 50);
    wr(8'h1C, 0);

    // R10 reload zero on channel 3
    wr(8'h50, 32'h9); wr(8'h54, 0); wr(8'h1C, 32'h1000);
    rd(8'h58, rv); chk("R10 count stays 0", rv, 0);
    wr(8'h18, 32'h1000);
    rd(8'h18, rv); chk("R10 set wins over clear", rv & 32'h1000, 32'h1000);
    wr(8'h14, 32'h1000);
    chk("R7 irq ch3", {31'b0, irq}, 1);
    wr(8'h1C, 0); wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, rv); chk("R6 all cleared", rv, 0);
    chk("R7 irq off", {31'b0, irq}, 0);

    // R11 unimplemented bits
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, rv); chk("R11 enable bits", rv, 32'h1111);
    wr(8'h1C, 0);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, rv); chk("R11 ien bits", rv, 32'h1111);
    wr(8'h14, 0);
    wr(8'h20, 32'hFF); rd(8'h20, rv); chk("R11 control bits", rv, 32'h0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule